// File: doc/BRIEF.md
# Trace Capture Ring Buffer

The block records one 256-bit trace word per clock into a circular on-chip memory. Recording continues until the memory wraps and then overwrites the oldest entries. The result is a rolling window of the most recent activity. Two register-style access ports are provided, one for software and one for a debug interface. Each port can stop recording and read the stored data back as 64-bit doublewords.

Each port has a control register and a data register.
- The control register shows the write position in its upper half, counted in whole entries. It shows that port's read position in its lower half, counted in doublewords.
- The buffer depth is OR-ed into the write position field. Software can therefore recover the depth from the position of the highest set bit.
- Bit 31 of each control register is a freeze flag. While either port's flag is set, no entry is written and the stored contents stay stable.
- Reading the data register returns the doubleword at that port's read position, then steps the position forward.

The depth is a build-time parameter. A depth of zero removes the storage and the capture logic entirely.

Top module: `trace_ring`

## Requirements
- R1: While `trace_en` is high and no freeze flag is set, each clock edge stores `trace_data` at the write position and advances the write position by one entry.
- R2: After the last entry (DEPTH-1), the write position returns to 0, and later captures overwrite the oldest entries.
- R3: Control read bits [63:32] equal the write position OR DEPTH (DEPTH a power of two). The depth therefore equals 1 shifted left by the index of the highest set bit of that field.
- R4: Control read bit 31 is the port's freeze flag, and bits [30:0] are the port's read position in doublewords. A write pulse loads the flag from write-data bit 31 and the position from bits [30:0], reduced modulo DEPTH*4.
- R5: A data read pulse places one doubleword on the port's data output, valid the cycle after the pulse. The doubleword is lane k of entry e, where e is the position divided by 4 and k is the position modulo 4; lane k is bits [64k+63:64k]. The read position then advances by one. A control write in the same cycle takes priority over the read.
- R6: The read position wraps modulo DEPTH*4.
- R7: While either port's freeze flag is set, `trace_en` has no effect: the write position and the stored contents stay unchanged.
- R8: The two ports keep separate read positions and separate freeze flags. An access on one port leaves the other port's lower control field unchanged.
- R9: After reset, the write position, both read positions, both freeze flags and both data outputs are zero.
- R10: With DEPTH = 0, no storage exists, data reads return zero, and control bits [63:32] and [30:0] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Capture the trace word this cycle |
| trace_data | input | 256 | Trace word to capture |
| sw_ctl_we | input | 1 | Software port control register write |
| sw_ctl_wdata | input | 32 | Software port control write data (freeze flag, read position) |
| sw_ctl_rdata | output | 64 | Software port control register value |
| sw_data_re | input | 1 | Software port data read pulse |
| sw_data_rdata | output | 64 | Software port doubleword read result |
| dbg_ctl_we | input | 1 | Debug port control register write |
| dbg_ctl_wdata | input | 32 | Debug port control write data (freeze flag, read position) |
| dbg_ctl_rdata | output | 64 | Debug port control register value |
| dbg_data_re | input | 1 | Debug port data read pulse |
| dbg_data_rdata | output | 64 | Debug port doubleword read result |

## Verification
The bench builds one instance with DEPTH = 8 and a second with DEPTH = 0.

The small depth lets eleven captures run the write position past its wrap. With 32 doublewords in total, read-position wrap and the modulo reduction of oversized pointer writes are exercised in a few steps, and the read-back order is checked against a model of the slots.

The zero-depth instance exercises the variant in which no storage is generated. Freezing is applied from each port in turn, and each freeze is checked while the other port keeps reading.

// File: rtl/trace_ring.sv
module trace_ring #(
  parameter int DEPTH = 2048,
  parameter int DW    = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trace_en,
  input  logic [DW-1:0] trace_data,
  input  logic          sw_ctl_we,
  input  logic [31:0]   sw_ctl_wdata,
  output logic [63:0]   sw_ctl_rdata,
  input  logic          sw_data_re,
  output logic [63:0]   sw_data_rdata,
  input  logic          dbg_ctl_we,
  input  logic [31:0]   dbg_ctl_wdata,
  output logic [63:0]   dbg_ctl_rdata,
  input  logic          dbg_data_re,
  output logic [63:0]   dbg_data_rdata
);
  localparam int LANES = DW / 64;
  localparam int LW    = $clog2(LANES);
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RW    = PW + LW;
  localparam logic [30:0] RMASK = (DEPTH > 0) ? 31'(DEPTH * LANES - 1) : 31'd0;

  logic [1:0]  ctl_we, data_re, frz;
  logic [31:0] ctl_wd [2];
  logic [30:0] rp     [2];
  logic [63:0] dq     [2];
  logic [31:0] wp_field;

  assign ctl_we    = {dbg_ctl_we, sw_ctl_we};
  assign data_re   = {dbg_data_re, sw_data_re};
  assign ctl_wd[0] = sw_ctl_wdata;
  assign ctl_wd[1] = dbg_ctl_wdata;

  assign sw_ctl_rdata   = {wp_field, frz[0], rp[0]};
  assign dbg_ctl_rdata  = {wp_field, frz[1], rp[1]};
  assign sw_data_rdata  = dq[0];
  assign dbg_data_rdata = dq[1];

  generate
    if (DEPTH > 0) begin : g_store
      logic [DW-1:0] mem [DEPTH];
      logic [PW-1:0] wp;
      wire           cap = trace_en && !(|frz);

      always_ff @(posedge clk)
        if (cap) mem[wp] <= trace_data;

      always_ff @(posedge clk)
        if (!rst_n)   wp <= '0;
        else if (cap) wp <= wp + 1'b1;

      assign wp_field = 32'(wp) | 32'(DEPTH);

      for (genvar p = 0; p < 2; p++) begin : g_port
        logic        f_q;
        logic [30:0] r_q;
        logic [63:0] d_q;
        wire  [RW-1:0] ri = r_q[RW-1:0];

        always_ff @(posedge clk)
          if (!rst_n) begin
            f_q <= 1'b0;
            r_q <= '0;
            d_q <= '0;
          end else if (ctl_we[p]) begin
            f_q <= ctl_wd[p][31];
            r_q <= ctl_wd[p][30:0] & RMASK;
          end else if (data_re[p]) begin
            d_q <= mem[ri[RW-1:LW]][{ri[LW-1:0], 6'b0} +: 64];
            r_q <= (r_q + 31'd1) & RMASK;
          end

        assign frz[p] = f_q;
        assign rp[p]  = r_q;
        assign dq[p]  = d_q;
      end
    end else begin : g_none
      assign wp_field = '0;
      for (genvar p = 0; p < 2; p++) begin : g_port
        logic f_q;
        always_ff @(posedge clk)
          if (!rst_n)         f_q <= 1'b0;
          else if (ctl_we[p]) f_q <= ctl_wd[p][31];
        assign frz[p] = f_q;
        assign rp[p]  = ctl_wd[p][30:0] & RMASK;
        assign dq[p]  = {63'd0, data_re[p] & 1'b0};
      end
    end
  endgenerate
endmodule

// File: rtl/trace_ring_chk.sv
module trace_ring_chk #(
  parameter int DEPTH = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        trace_en,
  input logic        sw_ctl_we,
  input logic [31:0] sw_ctl_wdata,
  input logic        sw_data_re,
  input logic [63:0] sw_ctl_rdata,
  input logic        dbg_ctl_we,
  input logic        dbg_data_re,
  input logic [63:0] dbg_ctl_rdata
);
  localparam logic [30:0] M = (DEPTH > 0) ? 31'(DEPTH * 4 - 1) : 31'd0;
  wire fz = sw_ctl_rdata[31] | dbg_ctl_rdata[31];

  a_r7_freeze_holds_wp: assert property (@(posedge clk) disable iff (!rst_n)
    fz |=> $stable(sw_ctl_rdata[63:32]));

  a_r4_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ctl_we |=> sw_ctl_rdata[31:0] == {$past(sw_ctl_wdata[31]), $past(sw_ctl_wdata[30:0]) & M});

  a_r5_rp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_data_re && !sw_ctl_we) |=> sw_ctl_rdata[30:0] == (($past(sw_ctl_rdata[30:0]) + 31'd1) & M));

  a_r8_dbg_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_ctl_we && !dbg_data_re) |=> $stable(dbg_ctl_rdata[31:0]));

  generate
    if (DEPTH > 1) begin : g_wp
      localparam logic [31:0] WM = 32'(DEPTH - 1);
      a_r1_wp_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && !fz) |=> sw_ctl_rdata[63:32] ==
          ((((($past(sw_ctl_rdata[63:32]) & WM) + 32'd1)) & WM) | 32'(DEPTH)));
    end
  endgenerate
endmodule

bind trace_ring trace_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
  .sw_ctl_we(sw_ctl_we), .sw_ctl_wdata(sw_ctl_wdata), .sw_data_re(sw_data_re),
  .sw_ctl_rdata(sw_ctl_rdata), .dbg_ctl_we(dbg_ctl_we), .dbg_data_re(dbg_data_re),
  .dbg_ctl_rdata(dbg_ctl_rdata)
);

// File: tb/trace_ring_test.sv
module trace_ring_test;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic clk = 1'b0, rst_n = 1'b0, trace_en = 1'b0;
  logic [255:0] trace_data = '0;
  logic [1:0]   we = '0, re = '0;
  logic [31:0]  wd [2];
  logic [63:0]  cr [2], dr [2];
  logic         zwe = 1'b0, zre = 1'b0;
  logic [63:0]  zcr, zdr, zcr2, zdr2;
  int checks = 0, errors = 0;
  int model [D];
  int wpm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_ring #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .trace_data(trace_data),
    .sw_ctl_we(we[0]), .sw_ctl_wdata(wd[0]), .sw_ctl_rdata(cr[0]),
    .sw_data_re(re[0]), .sw_data_rdata(dr[0]),
    .dbg_ctl_we(we[1]), .dbg_ctl_wdata(wd[1]), .dbg_ctl_rdata(cr[1]),
    .dbg_data_re(re[1]), .dbg_data_rdata(dr[1]));

  trace_ring #(.DEPTH(0)) uz (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .trace_data(trace_data),
    .sw_ctl_we(zwe), .sw_ctl_wdata(32'h0000_0005), .sw_ctl_rdata(zcr),
    .sw_data_re(zre), .sw_data_rdata(zdr),
    .dbg_ctl_we(1'b0), .dbg_ctl_wdata(32'h0), .dbg_ctl_rdata(zcr2),
    .dbg_data_re(1'b0), .dbg_data_rdata(zdr2));

  localparam logic [7:0] RDS [6] = '{8'd0, 8'd3, 8'd13, 8'd30, 8'd31, 8'd45};

  function automatic logic [63:0] dw(int n, int k);
    return {16'hBEEF, 16'(n), 16'(k), 16'(n) ^ 16'h5A5A};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic capture(int n, bit frozen);
    @(negedge clk);
    trace_en = 1'b1;
    trace_data = {dw(n,3), dw(n,2), dw(n,1), dw(n,0)};
    @(negedge clk);
    trace_en = 1'b0;
    if (!frozen) begin model[wpm] = n; wpm = (wpm + 1) % D; end
  endtask

  task automatic ctl(int p, logic [31:0] v);
    @(negedge clk); we[p] = 1'b1; wd[p] = v;
    @(negedge clk); we[p] = 1'b0;
  endtask

  task automatic rd(int p, output logic [63:0] v);
    @(negedge clk); re[p] = 1'b1;
    @(negedge clk); re[p] = 1'b0; v = dr[p];
  endtask

  function automatic logic [63:0] expect_at(int q);
    return dw(model[(q & (4*D-1)) >> 2], q & 3);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int h;
    wd[0] = '0; wd[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 reset sw ctl", cr[0], {32'd8, 32'd0});
    check("R9 reset dbg ctl", cr[1], {32'd8, 32'd0});
    check("R9 reset sw data", dr[0], 64'd0);

    for (int n = 0; n < 11; n++) capture(n, 0);
    check("R2 wp wrapped to 3", {32'd0, cr[0][63:32]}, 64'd11);
    h = 0;
    for (int b = 0; b < 32; b++) if (cr[0][32+b]) h = b;
    check("R3 length from highest bit", 64'(1 << h), 64'd8);

    ctl(0, 32'h8000_0000);
    check("R4 sw freeze flag", {63'd0, cr[0][31]}, 64'd1);
    for (int n = 11; n < 14; n++) capture(n, 1);
    check("R7 wp held by sw freeze", {32'd0, cr[0][63:32]}, 64'd11);

    foreach (RDS[i]) begin
      ctl(0, 32'h8000_0000 | 32'(RDS[i]));
      check("R4 rp load masked", {32'd0, cr[0][31:0]}, {32'd0, 32'h8000_0000 | 32'(RDS[i] & 8'd31)});
      for (int j = 0; j < 3; j++) begin
        rd(0, v);
        check("R5 R2 read order", v, expect_at(int'(RDS[i]) + j));
      end
      check("R6 rp after reads", {33'd0, cr[0][30:0]}, 64'((int'(RDS[i]) + 3) & 31));
    end

    ctl(0, 32'h0);
    capture(20, 0);
    capture(21, 0);
    check("R1 wp advanced by two", {32'd0, cr[0][63:32]}, 64'd13);

    ctl(1, 32'h8000_000C);
    check("R8 sw flag clear", {32'd0, cr[0][31:0]}, 64'd0);
    capture(30, 1);
    capture(31, 1);
    check("R7 wp held by dbg freeze", {32'd0, cr[1][63:32]}, 64'd13);
    rd(1, v);
    check("R1 dbg reads new entry", v, dw(20, 0));
    rd(0, v);
    check("R8 sw reads own rp", v, dw(8, 0));
    check("R8 dbg rp unaffected", {32'd0, cr[1][31:0]}, 64'h8000_000D);
    rd(1, v);
    check("R7 contents unchanged", v, dw(20, 1));

    @(negedge clk); zwe = 1'b1;
    @(negedge clk); zwe = 1'b0; zre = 1'b1;
    @(negedge clk); zre = 1'b0;
    check("R10 zero-depth data", zdr, 64'd0);
    check("R10 zero-depth ctl", zcr, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule